// File: doc/BRIEF.md
# Delayed Power-Good Generator

This block drives the power-good indication of a switching supply monitor. It takes plain control flags from other blocks: one flag per main rail (3.3 V and 5 V), true when the rail is above its under-voltage threshold; a raw power-good-input flag; the debounced on/off state, which is high while the supply is commanded off; and the fault-latch state from the fault controller. It combines them into one power-good output.

The output is asymmetric. It rises only after every condition has been good without a break for a long qualification window. It falls at once when a rail flag drops, when the supply is commanded off or when a fault is latched. The power-good-input flag first passes a short deglitch filter, so a change on it counts only once it has held for a set number of samples. Both lengths are parameters in clock cycles: about 300 ms and 150 us at the clock in use.

All pins are plain control levels. No data stream crosses the block, so there is no valid/ready handshake and no back-pressure.

Top module: `pgood_gen`

## Requirements
- R1: While reset is asserted, and right after it is released, pg_out is 0. The qualification counter and the filtered power-good input both start cleared, so the first rise needs the full filter length plus the full qualification length.
- R2: Take the first clock edge at which all conditions are good, with the filtered input already good. pg_out goes to 1 right after the QUAL_CYCLES-th consecutive such edge and not before. "All conditions good" means rail3v3_ok=1, rail5v_ok=1, filtered pgi=1, supply_off=0 and fault_latched=0.
- R3: When rail3v3_ok or rail5v_ok goes to 0, pg_out is 0 in the same cycle, with no clock edge in between.
- R4: A change of pgi_raw takes effect only once pgi_raw has held the new value on GLITCH_CYCLES consecutive clock edges. A shorter excursion leaves pg_out unchanged.
- R5: If pgi_raw falls and stays 0, pg_out goes to 0 right after the GLITCH_CYCLES-th edge that samples it low.
- R6: While supply_off is 1, pg_out is 0 in the same cycle, whatever the other inputs are.
- R7: While fault_latched is 1, pg_out is 0 in the same cycle, whatever the other inputs are.
- R8: Any loss of a good condition, even for a single sampled edge, restarts qualification from zero. A full QUAL_CYCLES of good edges is then needed again.
- R9: Once pg_out is 1, it stays 1 for as long as all conditions stay good.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rail3v3_ok | input | 1 | 1 = 3.3 V rail above its under-voltage threshold |
| rail5v_ok | input | 1 | 1 = 5 V rail above its under-voltage threshold |
| pgi_raw | input | 1 | Unfiltered power-good-input flag, 1 = good |
| supply_off | input | 1 | Debounced on/off state, 1 = supply commanded off |
| fault_latched | input | 1 | 1 = fault latch set in the fault controller |
| pg_out | output | 1 | Power-good output, 1 = good |

## Verification
A wrong qualification count appears at pg_out as a rise one or more cycles early or late, so the first full good window after reset exposes it. A stuck or miscounted filter state changes when a drop or recovery of pgi_raw reaches the output, which is visible within GLITCH_CYCLES edges of the input change. A missing restart of the window after a short dropout appears as an early rise on the next qualification. A gating error on the rails, the off state or the fault latch appears in the very cycle the input changes, because those paths hold no register.

// File: rtl/pgp_pkg.sv
package pgp_pkg;

  // Snapshot of every condition that gates the power-good output.
  typedef struct packed {
    logic rail3;
    logic rail5;
    logic pgi;
    logic off;
    logic fault;
  } pg_cond_t;

  // Counter width that can hold the value n.
  function automatic int unsigned cnt_bits(input int unsigned n);
    return (n < 2) ? 1 : $clog2(n + 1);
  endfunction

endpackage

// File: rtl/pgp_deglitch.sv
module pgp_deglitch #(
  parameter int unsigned HOLD = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic raw,
  output logic filt
);
  localparam int unsigned CW = pgp_pkg::cnt_bits(HOLD);

  generate
    if (HOLD == 0) begin : g_pass
      assign filt = raw;
    end else if (HOLD == 1) begin : g_reg
      logic filt_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) filt_q <= 1'b0;
        else        filt_q <= raw;
      end
      assign filt = filt_q;
    end else begin : g_count
      logic          filt_q;
      logic [CW-1:0] diff_cnt;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          filt_q   <= 1'b0;
          diff_cnt <= '0;
        end else if (raw == filt_q) begin
          diff_cnt <= '0;
        end else if (diff_cnt == CW'(HOLD - 1)) begin
          filt_q   <= raw;
          diff_cnt <= '0;
        end else begin
          diff_cnt <= diff_cnt + 1'b1;
        end
      end
      assign filt = filt_q;
    end
  endgenerate

endmodule

// File: rtl/pgp_qual_timer.sv
module pgp_qual_timer #(
  parameter int unsigned QUAL = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic good,
  output logic qualified
);
  localparam int unsigned CW = pgp_pkg::cnt_bits(QUAL);

  logic done_q;

  generate
    if (QUAL <= 1) begin : g_short
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) done_q <= 1'b0;
        else        done_q <= good;
      end
    end else begin : g_long
      logic [CW-1:0] run_cnt;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          run_cnt <= '0;
          done_q  <= 1'b0;
        end else if (!good) begin
          run_cnt <= '0;
          done_q  <= 1'b0;
        end else if (!done_q) begin
          if (run_cnt == CW'(QUAL - 1)) done_q <= 1'b1;
          else                          run_cnt <= run_cnt + 1'b1;
        end
      end
    end
  endgenerate

  assign qualified = done_q;

endmodule

// File: rtl/pgp_gate.sv
module pgp_gate (
  input  pgp_pkg::pg_cond_t cond,
  output logic              all_good
);
  always_comb begin
    all_good = cond.rail3 & cond.rail5 & cond.pgi & ~cond.off & ~cond.fault;
  end
endmodule

// File: rtl/pgood_gen.sv
module pgood_gen #(
  parameter int unsigned QUAL_CYCLES   = 15_000_000,
  parameter int unsigned GLITCH_CYCLES = 7_500
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rail3v3_ok,
  input  logic rail5v_ok,
  input  logic pgi_raw,
  input  logic supply_off,
  input  logic fault_latched,
  output logic pg_out
);
  import pgp_pkg::*;

  logic     pgi_filt;
  logic     all_good;
  logic     qualified;
  pg_cond_t cond;

  pgp_deglitch #(.HOLD(GLITCH_CYCLES)) u_pgi_flt (
    .clk  (clk),
    .rst_n(rst_n),
    .raw  (pgi_raw),
    .filt (pgi_filt)
  );

  always_comb begin
    cond.rail3 = rail3v3_ok;
    cond.rail5 = rail5v_ok;
    cond.pgi   = pgi_filt;
    cond.off   = supply_off;
    cond.fault = fault_latched;
  end

  pgp_gate u_gate (
    .cond    (cond),
    .all_good(all_good)
  );

  pgp_qual_timer #(.QUAL(QUAL_CYCLES)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .good     (all_good),
    .qualified(qualified)
  );

  // Rising needs the registered qualification; falling follows all_good at once.
  assign pg_out = all_good & qualified;

endmodule

// File: rtl/pgood_gen_chk.sv
module pgood_gen_chk #(
  parameter int unsigned QUAL_CYCLES   = 15_000_000,
  parameter int unsigned GLITCH_CYCLES = 7_500
) (
  input logic clk,
  input logic rst_n,
  input logic rail3v3_ok,
  input logic rail5v_ok,
  input logic pgi_raw,
  input logic supply_off,
  input logic fault_latched,
  input logic pg_out
);
  int unsigned port_run;
  int unsigned low_run;
  logic        port_good;

  assign port_good = rail3v3_ok & rail5v_ok & ~supply_off & ~fault_latched;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      port_run <= 0;
      low_run  <= 0;
    end else begin
      if (!port_good)                port_run <= 0;
      else if (port_run < QUAL_CYCLES) port_run <= port_run + 1;
      if (pgi_raw)                   low_run <= 0;
      else if (low_run < GLITCH_CYCLES) low_run <= low_run + 1;
    end
  end

  p_rail_drop_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!rail3v3_ok || !rail5v_ok) |-> !pg_out);

  p_off_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
    supply_off |-> !pg_out);

  p_fault_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
    fault_latched |-> !pg_out);

  // R2 / R8: high output implies a full unbroken window of good port conditions.
  p_full_window_r2: assert property (@(posedge clk) disable iff (!rst_n)
    pg_out |-> (port_run >= QUAL_CYCLES));

  p_pgi_loss_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ((GLITCH_CYCLES > 0) && (low_run >= GLITCH_CYCLES)) |-> !pg_out);

endmodule

bind pgood_gen pgood_gen_chk #(
  .QUAL_CYCLES  (QUAL_CYCLES),
  .GLITCH_CYCLES(GLITCH_CYCLES)
) u_chk (.*);

// File: tb/tb_pgood_gen.sv
`timescale 1ns/1ps
module tb_pgood_gen;
  localparam int unsigned Q = 40;
  localparam int unsigned G = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rail3v3_ok = 1'b0, rail5v_ok = 1'b0, pgi_raw = 1'b0;
  logic supply_off = 1'b1, fault_latched = 1'b0;
  logic pg_out;

  int n_tests = 0;
  int n_fail  = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  pgood_gen #(.QUAL_CYCLES(Q), .GLITCH_CYCLES(G)) dut (
    .clk(clk), .rst_n(rst_n), .rail3v3_ok(rail3v3_ok), .rail5v_ok(rail5v_ok),
    .pgi_raw(pgi_raw), .supply_off(supply_off), .fault_latched(fault_latched),
    .pg_out(pg_out)
  );

  // Reference model built from the requirements.
  logic        m_filt = 1'b0;
  int unsigned m_diff = 0;
  int unsigned m_run  = 0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_filt = 1'b0; m_diff = 0; m_run = 0;
    end else begin
      if (rail3v3_ok && rail5v_ok && m_filt && !supply_off && !fault_latched)
        m_run = (m_run < Q) ? m_run + 1 : Q;
      else
        m_run = 0;
      if (pgi_raw != m_filt) begin
        if (m_diff + 1 >= G) begin m_filt = pgi_raw; m_diff = 0; end
        else m_diff = m_diff + 1;
      end else m_diff = 0;
    end
  end

  function automatic logic model_pg();
    return rail3v3_ok && rail5v_ok && m_filt && !supply_off && !fault_latched
           && (m_run >= Q);
  endfunction

  task automatic check(input string tag, input logic exp);
    n_tests++;
    if (pg_out !== exp) begin
      n_fail++;
      $display("FAIL %s: pg_out=%b expected=%b at %0t", tag, pg_out, exp, $time);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: run did not end, expected completion");
    finish_run();
  end

  initial begin
    tick(3);
    check("R1 in reset", 1'b0);
    rst_n = 1'b1;
    tick(1);
    check("R1 after reset", 1'b0);

    // R2: first rise needs G filter edges plus Q qualification edges.
    rail3v3_ok = 1; rail5v_ok = 1; pgi_raw = 1; supply_off = 0; fault_latched = 0;
    tick(G + Q - 1);
    check("R2 one edge early", 1'b0);
    tick(1);
    check("R2 rise", 1'b1);
    tick(10);
    check("R9 stays high", 1'b1);

    // R3 and R8: rail drop falls at once, recovery needs a full window.
    rail3v3_ok = 0; #1;
    check("R3 3v3 drop same cycle", 1'b0);
    tick(1); rail3v3_ok = 1;
    tick(Q - 1);
    check("R8 window restarted", 1'b0);
    tick(1);
    check("R8 requalified", 1'b1);

    rail5v_ok = 0; #1;
    check("R3 5v drop same cycle", 1'b0);
    tick(1); rail5v_ok = 1;
    tick(Q - 1);
    check("R8 single-edge dropout", 1'b0);
    tick(1);
    check("R8 requalified after dropout", 1'b1);

    // R4: pgi excursion shorter than G has no effect.
    pgi_raw = 0; #1;
    check("R4 glitch start", 1'b1);
    tick(G - 1);
    check("R4 glitch held G-1", 1'b1);
    pgi_raw = 1;
    tick(2);
    check("R4 glitch ignored", 1'b1);

    // R5: pgi low for G edges drops output.
    pgi_raw = 0;
    tick(G - 1);
    check("R5 before filter length", 1'b1);
    tick(1);
    check("R5 pgi loss", 1'b0);
    pgi_raw = 1;
    tick(G + Q - 1);
    check("R4 recovery early", 1'b0);
    tick(1);
    check("R4 recovery rise", 1'b1);

    // R6: supply off forces low.
    supply_off = 1; #1;
    check("R6 off same cycle", 1'b0);
    tick(3); supply_off = 0;
    tick(Q - 1);
    check("R6 after on early", 1'b0);
    tick(1);
    check("R6 after on rise", 1'b1);

    // R7: fault latch forces low.
    fault_latched = 1; #1;
    check("R7 fault same cycle", 1'b0);
    rail3v3_ok = 1; rail5v_ok = 1;
    tick(Q + 5);
    check("R7 held by fault", 1'b0);
    fault_latched = 0;
    tick(Q);
    check("R7 after clear", 1'b1);

    // Random phase against the model.
    void'($urandom(32'h5eed_1234));
    for (int i = 0; i < 6000; i++) begin
      rail3v3_ok    = ($urandom_range(0, 199) != 0);
      rail5v_ok     = ($urandom_range(0, 199) != 0);
      pgi_raw       = (i % 700 < 20) ? 1'b0 : ($urandom_range(0, 49) != 0);
      supply_off    = ($urandom_range(0, 399) == 0);
      fault_latched = ($urandom_range(0, 499) == 0);
      #1;
      check("R2/R8 random same cycle", model_pg());
      tick(1);
      check("R9 random after edge", model_pg());
    end

    finish_run();
  end

endmodule